// File: doc/BRIEF.md
# Packet Header Deframer

This block turns a packetized 64-bit AXI4-Stream into a plain sample stream. The first word of each packet is a header. A flag inside that header says whether a 64-bit timestamp word follows it. The block removes the header word, and the timestamp word when present, so that only payload words produce output beats. The decoded header and timestamp are carried on a 128-bit user sideband that travels with every payload beat of the packet.

The output width is a build parameter of 32 or 64 bits. At 32 bits each 64-bit payload word leaves as two beats, upper half first. Packets of every type pass through unchanged in meaning. A packet that holds only a header, or only a header and a timestamp, produces no output beats. One clock domain is used. A synchronous clear drops any packet in progress.

Top module: `pkt_deframer`

## Requirements
- R1: The user sideband bits [127:64] of every output beat equal the first input word of that beat's packet. That word holds the type in [63:62], has-time in [61], end-of-burst in [60], sequence in [59:48], byte length in [47:32], source ID in [31:16] and destination ID in [15:0].
- R2: When has-time (header bit 61) is 1, the second input word is not output, and its value appears on user bits [63:0] of every beat of the packet.
- R3: When has-time is 0, payload begins with the second input word, and user bits [63:0] are zero.
- R4: Header and timestamp words produce no output beat. The input ready is high whenever a timestamp word is offered. A header word is accepted once the previous packet's last beat has been accepted.
- R5: With a 64-bit output, each payload word produces exactly one beat carrying that word. Output last is high only on the beat of the input word that had last set.
- R6: With a 32-bit output, each payload word produces two beats: bits [63:32] first, then bits [31:0]. Output last is high only on the second beat of the packet's final word.
- R7: A packet whose last flag is on its header word (has-time 0) or on its timestamp word (has-time 1) produces no output beats.
- R8: The user sideband stays constant across all beats of a packet. It changes only after that packet's last beat has been accepted.
- R9: While output valid is high and output ready is low, output valid, data and last hold their values.
- R10: After reset, or one cycle after the clear input is high, output valid is low, the user sideband is zero, and the next input word is taken as a header.
- R11: All four type codes (00 data, 01 flow control, 10 command, 11 response) are treated alike and passed through on user bits [127:126].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of the parser and the held word |
| in_data_i | input | 64 | Packet stream data |
| in_last_i | input | 1 | Last word of packet |
| in_valid_i | input | 1 | Input word valid |
| in_ready_o | output | 1 | Input word accepted when high with valid |
| out_data_o | output | OUT_W | Payload element |
| out_user_o | output | 128 | Header in [127:64], timestamp in [63:0] |
| out_last_o | output | 1 | Final element of the packet |
| out_valid_o | output | 1 | Output beat valid |
| out_ready_i | input | 1 | Output beat accepted when high with valid |

## Verification
The bench builds two copies side by side, one with OUT_W=32 and one with OUT_W=64, so both the word-splitting path and the pass-through path run against the same packet sweep. For each copy the sweep covers every type code, both settings of has-time, and payload lengths from zero to four words. It runs once with output ready held high and once under pseudo-random backpressure. This reaches header-only and timestamp-only packets, back-to-back packets where the next header must wait for the last beat, and held beats under stall. A clear issued in the middle of a packet on the 32-bit copy checks that a partial packet is dropped.

// File: rtl/pkt_deframer_pkg.sv
package pkt_deframer_pkg;
  localparam int IN_W   = 64;
  localparam int USER_W = 128;

  typedef enum logic [1:0] {
    ST_HDR = 2'd0,
    ST_TS  = 2'd1,
    ST_PAY = 2'd2
  } parse_st_e;

  typedef struct packed {
    logic [1:0]  kind;
    logic        has_ts;
    logic        eob;
    logic [11:0] seq;
    logic [15:0] len;
    logic [15:0] src;
    logic [15:0] dst;
  } hdr_t;
endpackage

// File: rtl/pkt_hdr_fsm.sv
module pkt_hdr_fsm
  import pkt_deframer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic [IN_W-1:0]   in_data_i,
  input  logic              in_last_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic              slot_empty_i,
  input  logic              slot_free_i,
  output logic              word_load_o,
  output logic [USER_W-1:0] user_o
);
  parse_st_e       state_q;
  hdr_t            hdr_q;
  logic [IN_W-1:0] ts_q;
  logic            fire;
  hdr_t            hdr_in;

  assign hdr_in = hdr_t'(in_data_i);

  // header waits for the previous packet's final beat; timestamp never stalls
  always_comb begin
    unique case (state_q)
      ST_PAY:  in_ready_o = slot_free_i;
      ST_TS:   in_ready_o = 1'b1;
      default: in_ready_o = slot_empty_i;
    endcase
  end

  assign fire        = in_valid_i & in_ready_o;
  assign word_load_o = fire & (state_q == ST_PAY);
  assign user_o      = {hdr_q, ts_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HDR;
      hdr_q   <= '0;
      ts_q    <= '0;
    end else if (clear_i) begin
      state_q <= ST_HDR;
      hdr_q   <= '0;
      ts_q    <= '0;
    end else if (fire) begin
      unique case (state_q)
        ST_HDR: begin
          hdr_q <= hdr_in;
          ts_q  <= '0;
          if (hdr_in.has_ts)  state_q <= ST_TS;
          else if (in_last_i) state_q <= ST_HDR;
          else                state_q <= ST_PAY;
        end
        ST_TS: begin
          ts_q    <= in_data_i;
          state_q <= in_last_i ? ST_HDR : ST_PAY;
        end
        default: begin
          if (in_last_i) state_q <= ST_HDR;
        end
      endcase
    end
  end

  // R3: no timestamp retained while streaming a packet without one
  p_ts_zero_pay_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PAY && !hdr_q.has_ts) |-> (ts_q == '0));

  // R4: a header word with a timestamp leads to the timestamp state
  p_hdr_to_ts_r4: assert property (@(posedge clk_i) disable iff (!rst_ni || clear_i)
    (fire && state_q == ST_HDR && in_data_i[61]) |=> (state_q == ST_TS));
endmodule

// File: rtl/pkt_beat_split.sv
module pkt_beat_split
  import pkt_deframer_pkg::*;
#(
  parameter int OUT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             load_i,
  input  logic [IN_W-1:0]  word_i,
  input  logic             last_i,
  input  logic             out_ready_i,
  output logic [OUT_W-1:0] out_data_o,
  output logic             out_last_o,
  output logic             out_valid_o,
  output logic             slot_empty_o,
  output logic             slot_free_o
);
  localparam int PARTS = IN_W / OUT_W;
  localparam int SEL_W = (PARTS > 1) ? $clog2(PARTS) : 1;
  localparam logic [SEL_W-1:0] FINAL = SEL_W'(PARTS - 1);

  logic [IN_W-1:0]  word_q;
  logic             last_q;
  logic             full_q;
  logic [SEL_W-1:0] part_q;
  logic             final_part;
  logic             beat_fire;
  logic             drain;

  assign final_part   = (part_q == FINAL);
  assign beat_fire    = full_q & out_ready_i;
  assign drain        = beat_fire & final_part;
  assign slot_empty_o = ~full_q;
  assign slot_free_o  = ~full_q | drain;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      last_q <= 1'b0;
      full_q <= 1'b0;
      part_q <= '0;
    end else if (clear_i) begin
      last_q <= 1'b0;
      full_q <= 1'b0;
      part_q <= '0;
    end else if (load_i) begin
      word_q <= word_i;
      last_q <= last_i;
      full_q <= 1'b1;
      part_q <= '0;
    end else if (drain) begin
      full_q <= 1'b0;
      part_q <= '0;
    end else if (beat_fire) begin
      part_q <= part_q + 1'b1;
    end
  end

  // part 0 is the most significant slice
  generate
    if (PARTS > 1) begin : g_split
      assign out_data_o = word_q[(PARTS - 1 - int'(part_q)) * OUT_W +: OUT_W];

      // R6: the lower half always follows an accepted upper half
      p_split_order_r6: assert property (@(posedge clk_i) disable iff (!rst_ni || clear_i)
        (out_valid_o && out_ready_i && !final_part) |=> out_valid_o);
    end else begin : g_pass
      assign out_data_o = word_q;
    end
  endgenerate

  assign out_last_o  = last_q & final_part;
  assign out_valid_o = full_q;

  // R9: stalled beat is held
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni || clear_i)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o) && $stable(out_last_o)));

  // R10: clear empties the output
  p_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !out_valid_o);
endmodule

// File: rtl/pkt_deframer.sv
module pkt_deframer
  import pkt_deframer_pkg::*;
#(
  parameter int OUT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic [63:0]      in_data_i,
  input  logic             in_last_i,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  output logic [OUT_W-1:0] out_data_o,
  output logic [127:0]     out_user_o,
  output logic             out_last_o,
  output logic             out_valid_o,
  input  logic             out_ready_i
);
  logic slot_empty;
  logic slot_free;
  logic word_load;

  pkt_hdr_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clear_i      (clear_i),
    .in_data_i    (in_data_i),
    .in_last_i    (in_last_i),
    .in_valid_i   (in_valid_i),
    .in_ready_o   (in_ready_o),
    .slot_empty_i (slot_empty),
    .slot_free_i  (slot_free),
    .word_load_o  (word_load),
    .user_o       (out_user_o)
  );

  pkt_beat_split #(.OUT_W(OUT_W)) u_split (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clear_i      (clear_i),
    .load_i       (word_load),
    .word_i       (in_data_i),
    .last_i       (in_last_i),
    .out_ready_i  (out_ready_i),
    .out_data_o   (out_data_o),
    .out_last_o   (out_last_o),
    .out_valid_o  (out_valid_o),
    .slot_empty_o (slot_empty),
    .slot_free_o  (slot_free)
  );

  // R8: sideband frozen until the final beat is taken
  p_user_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni || clear_i)
    (out_valid_o && !(out_ready_i && out_last_o)) |=> $stable(out_user_o));

  // R3: no timestamp flag means a zero timestamp field
  p_ts_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_user_o[125]) |-> (out_user_o[63:0] == 64'd0));
endmodule

// File: tb/sim_pkt_deframer.sv
module sim_pkt_deframer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear = 1'b0;
  always #4 clk = ~clk;

  logic [63:0] drv_data = '0;
  logic        drv_last = 1'b0;
  logic        drv_valid = 1'b0;
  int          tgt = 0;
  logic        ordy = 1'b0;
  logic        bp_on = 1'b0;
  logic        force_nr = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  logic        ir_a, ir_b;
  logic [31:0] od_a;
  logic [63:0] od_b;
  logic [127:0] ou_a, ou_b;
  logic        ol_a, ol_b, ov_a, ov_b;

  pkt_deframer #(.OUT_W(32)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear),
    .in_data_i(drv_data), .in_last_i(drv_last), .in_valid_i(drv_valid && tgt == 0),
    .in_ready_o(ir_a), .out_data_o(od_a), .out_user_o(ou_a), .out_last_o(ol_a),
    .out_valid_o(ov_a), .out_ready_i(ordy));

  pkt_deframer #(.OUT_W(64)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(1'b0),
    .in_data_i(drv_data), .in_last_i(drv_last), .in_valid_i(drv_valid && tgt == 1),
    .in_ready_o(ir_b), .out_data_o(od_b), .out_user_o(ou_b), .out_last_o(ol_b),
    .out_valid_o(ov_b), .out_ready_i(ordy));

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int pkt = 0;
  logic mon_on = 1'b0;

  logic [63:0]  ex_d [2][1024];
  logic         ex_l [2][1024];
  logic [127:0] ex_u [2][1024];
  int wr [2];
  int rd [2];

  logic        pv [2];
  logic        pr [2];
  logic [63:0] pd [2];

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic rdy();
    return (tgt == 0) ? ir_a : ir_b;
  endfunction

  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (force_nr) ordy <= 1'b0;
    else          ordy <= bp_on ? lfsr[3] : 1'b1;
  end

  task automatic mon_beat(input int t, input logic [63:0] d, input logic l, input logic [127:0] u);
    int i;
    i = rd[t];
    if (i >= wr[t]) begin
      chk(1'b0, "R4 R7 unexpected beat", {64'd0, d}, 128'd0);
      return;
    end
    if (t == 0) chk(d[31:0] == ex_d[t][i][31:0], "R6 split data", {96'd0, d[31:0]}, {96'd0, ex_d[t][i][31:0]});
    else        chk(d == ex_d[t][i], "R5 word data", {64'd0, d}, {64'd0, ex_d[t][i]});
    chk(l == ex_l[t][i], (t == 0) ? "R6 last" : "R5 last", {127'd0, l}, {127'd0, ex_l[t][i]});
    chk(u[127:64] == ex_u[t][i][127:64], "R1 R8 R11 user header", u, ex_u[t][i]);
    chk(u[63:0] == ex_u[t][i][63:0], ex_u[t][i][125] ? "R2 timestamp" : "R3 zero timestamp", u, ex_u[t][i]);
    rd[t] = i + 1;
  endtask

  always @(negedge clk) begin
    #2;
    if (mon_on) begin
      if (pv[0] && !pr[0]) chk(ov_a && od_a == pd[0][31:0], "R9 hold u0", {95'd0, ov_a, od_a}, {95'd0, 1'b1, pd[0][31:0]});
      if (pv[1] && !pr[1]) chk(ov_b && od_b == pd[1], "R9 hold u1", {63'd0, ov_b, od_b}, {63'd0, 1'b1, pd[1]});
      if (ov_a && ordy) mon_beat(0, {32'd0, od_a}, ol_a, ou_a);
      if (ov_b && ordy) mon_beat(1, od_b, ol_b, ou_b);
      pv[0] = ov_a; pr[0] = ordy; pd[0] = {32'd0, od_a};
      pv[1] = ov_b; pr[1] = ordy; pd[1] = od_b;
    end else begin
      pv[0] = 1'b0; pv[1] = 1'b0;
    end
  end

  task automatic push(input int t, input logic [63:0] d, input logic l, input logic [127:0] u);
    if (t == 0) begin
      ex_d[0][wr[0]] = {32'd0, d[63:32]}; ex_l[0][wr[0]] = 1'b0; ex_u[0][wr[0]] = u; wr[0]++;
      ex_d[0][wr[0]] = {32'd0, d[31:0]};  ex_l[0][wr[0]] = l;    ex_u[0][wr[0]] = u; wr[0]++;
    end else begin
      ex_d[1][wr[1]] = d; ex_l[1][wr[1]] = l; ex_u[1][wr[1]] = u; wr[1]++;
    end
  endtask

  task automatic send_word(input logic [63:0] d, input logic l, input bit must_rdy);
    @(negedge clk);
    drv_valid = 1'b1; drv_data = d; drv_last = l;
    #1;
    if (must_rdy) chk(rdy() == 1'b1, "R4 ready on timestamp word", {127'd0, rdy()}, 128'd1);
    while (!rdy()) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
  endtask

  function automatic logic [63:0] pay(input int p, input int k);
    return {16'hA000 + 16'(p), 16'(k), 32'(p * 977 + k * 31 + 5)};
  endfunction

  // n payload words; stop_after >= 0 sends only that many payload words without last
  task automatic send_packet(input int t, input int typ, input int ht, input int n,
                             input bit do_push, input int stop_after);
    logic [63:0] hdr, ts;
    logic [127:0] u;
    int sent;
    pkt++;
    hdr = {2'(typ), 1'(ht), 1'(n & 1), 12'(pkt), 16'(8 + 8 * ht + 8 * n),
           16'h1000 + 16'(pkt), 16'h2000 + 16'(typ)};
    ts  = {32'hC0DE0000 | 32'(pkt), 32'(pkt * 7 + 3)};
    u   = {hdr, (ht != 0) ? ts : 64'd0};
    sent = (stop_after >= 0) ? stop_after : n;
    if (do_push)
      for (int k = 0; k < n; k++) push(t, pay(pkt, k), k == n - 1, u);
    tgt = t;
    send_word(hdr, (ht == 0) && (n == 0) && (stop_after < 0), 1'b0);
    if (ht != 0) send_word(ts, (n == 0) && (stop_after < 0), 1'b1);
    for (int k = 0; k < sent; k++) send_word(pay(pkt, k), (k == n - 1) && (stop_after < 0), 1'b0);
    @(negedge clk);
    drv_valid = 1'b0; drv_last = 1'b0;
  endtask

  task automatic drain(input int t);
    int w;
    w = 0;
    while (rd[t] != wr[t] && w < 2000) begin
      @(negedge clk);
      w++;
    end
    repeat (4) @(negedge clk);
    chk(rd[t] == wr[t], "R4 R7 beat count", 128'(rd[t]), 128'(wr[t]));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog expired R1 act=%0d exp=done", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    wr[0] = 0; wr[1] = 0; rd[0] = 0; rd[1] = 0;
    pv[0] = 0; pv[1] = 0; pr[0] = 0; pr[1] = 0; pd[0] = 0; pd[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    chk(!ov_a && !ov_b, "R10 reset valid low", {126'd0, ov_a, ov_b}, 128'd0);
    chk(ou_a == 128'd0 && ou_b == 128'd0, "R10 reset user zero", ou_a | ou_b, 128'd0);
    chk(ir_a && ir_b, "R10 reset ready for header", {126'd0, ir_a, ir_b}, 128'd3);
    mon_on = 1'b1;

    for (int t = 0; t < 2; t++) begin
      for (int bp = 0; bp < 2; bp++) begin
        bp_on = 1'(bp);
        for (int ht = 0; ht < 2; ht++)
          for (int n = 0; n < 5; n++)
            for (int typ = 0; typ < 4; typ++)
              send_packet(t, typ, ht, n, 1'b1, -1);
      end
      drain(t);
    end

    // R10: clear mid-packet on u0
    bp_on = 1'b0;
    mon_on = 1'b0;
    force_nr = 1'b1;
    @(negedge clk);
    send_packet(0, 0, 1, 3, 1'b0, 1);
    @(negedge clk); #2;
    chk(ov_a == 1'b1, "R10 partial word pending", {127'd0, ov_a}, 128'd1);
    @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    #2;
    chk(!ov_a, "R10 clear valid low", {127'd0, ov_a}, 128'd0);
    chk(ou_a == 128'd0, "R10 clear user zero", ou_a, 128'd0);
    force_nr = 1'b0;
    @(negedge clk);
    mon_on = 1'b1;
    send_packet(0, 2, 0, 2, 1'b1, -1);
    send_packet(0, 3, 1, 1, 1'b1, -1);
    drain(0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule